// File: doc/BRIEF.md
# Code Fetch Address Router

This block sits between the instruction fetch unit and the program memories of an 8-bit controller. For each 16-bit fetch address it picks one of three targets: the main on-chip flash, the small top-of-space flash, or the off-chip bus. It also forms the physical address sent to that target. Three inputs steer the decision. The first is the level of the external-access strap. The second is a bit that makes the small flash visible at the top of the code space. The third is a two-bit shadow field that can fold the lowest 1, 2 or 4 KB of code space, where the interrupt vectors live, onto the small flash. This lets vectors keep working while the main flash is being rewritten.

The decode is combinational. The result is registered once, so target and physical address appear one clock after the fetch request. A parameter chooses a main flash of 16 KB or 32 KB.

Top module: `fetch_map_top`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with fetch_valid low, out_valid is 0. After a cycle with fetch_valid high, out_valid is 1 in the next cycle. Target and physical address are also registered, with one cycle of latency.
- R2: When ext_access_n is 0 (all external), every address 0000h-FFFFh goes to target EXT (code 2'd2) with the physical address equal to the logical address. No shadowing happens in this case.
- R3: When ext_access_n is 1 and no shadow applies, addresses below the main flash size (4000h when MAIN_KB=16, 8000h when MAIN_KB=32) go to target MAIN (code 2'd0) with the physical address equal to the logical address.
- R4: When ext_access_n is 1 and top_vis is 1, addresses F000h-FFFFh go to target TOP (code 2'd1) with the physical address equal to the logical address.
- R5: When ext_access_n is 1 and top_vis is 0, addresses F000h-FFFFh go to EXT unchanged.
- R6: When ext_access_n is 1, addresses from the end of the main flash up to EFFFh always go to EXT unchanged.
- R7: shadow_sel 00 disables shadowing. 01 shadows 0000h-03FFh, 10 shadows 0000h-07FFh, and 11 shadows 0000h-0FFFh.
- R8: A shadowed fetch goes to TOP with bits [15:12] of the physical address forced to 1 and bits [11:0] kept. The main flash locations it hides are never addressed. This holds whatever the value of top_vis.
- R9: A change of shadow_sel takes effect on the very next fetch, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch request is present this cycle |
| fetch_addr | input | 16 | Logical code address |
| ext_access_n | input | 1 | External-access strap level: 0 sends all fetches off chip |
| top_vis | input | 1 | Small flash visible at F000h-FFFFh |
| shadow_sel | input | 2 | Low-space shadow size select |
| out_valid | output | 1 | Registered result is valid |
| out_target | output | 2 | 0 main flash, 1 top flash, 2 external bus |
| out_addr | output | 16 | Physical address for the selected target |

## Verification
The hardest cases to reach are the boundaries of the shadow windows. The bench must catch 03FFh/0400h, 07FFh/0800h and 0FFFh/1000h while shadow_sel changes from one fetch to the next, and also while top_vis is low. The stimulus first sweeps every edge address under all mode combinations. It then runs a long pseudo-random phase in which the address, the strap, the visibility bit and shadow_sel all change every cycle. A behavioural model predicts each registered result one cycle ahead.

// File: rtl/fetch_map_pkg.sv
package fetch_map_pkg;
  typedef enum logic [1:0] {
    TGT_MAIN = 2'd0,
    TGT_TOP  = 2'd1,
    TGT_EXT  = 2'd2
  } fetch_tgt_e;

  typedef struct packed {
    fetch_tgt_e  tgt;
    logic [15:0] addr;
  } fetch_route_t;
endpackage

// File: rtl/fetch_shadow_dec.sv
module fetch_shadow_dec #(
  parameter int AW       = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 10
) (
  input  logic [AW-1:0]    addr,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int NSEL = 1 << SEL_W;
  logic [NSEL-1:0] win;

  // Window k (k >= 1) covers the lowest 2^(MIN_LOG2+k-1) addresses.
  assign win[0] = 1'b0;
  for (genvar k = 1; k < NSEL; k++) begin : g_win
    localparam int LG = MIN_LOG2 + k - 1;
    assign win[k] = (addr[AW-1:LG] == '0);
  end

  assign hit = win[sel];
endmodule

// File: rtl/fetch_route_comb.sv
module fetch_route_comb
  import fetch_map_pkg::*;
#(
  parameter int AW      = 16,
  parameter int MAIN_KB = 32,
  parameter int TOP_KB  = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          ext_n,
  input  logic          vis,
  input  logic          shadow_hit,
  output fetch_route_t  route
);
  localparam int MAIN_BYTES = MAIN_KB * 1024;
  localparam int TOP_BYTES  = TOP_KB * 1024;
  localparam int TOP_LOG2   = $clog2(TOP_BYTES);
  localparam int SPACE      = 1 << AW;
  localparam logic [AW:0] MAIN_END  = (AW+1)'(MAIN_BYTES);
  localparam logic [AW:0] TOP_START = (AW+1)'(SPACE - TOP_BYTES);

  logic in_main, in_top;
  assign in_main = {1'b0, addr} < MAIN_END;
  assign in_top  = {1'b0, addr} >= TOP_START;

  always_comb begin
    route.tgt  = TGT_EXT;
    route.addr = addr;
    if (ext_n) begin
      if (shadow_hit) begin
        route.tgt  = TGT_TOP;
        route.addr = {{(AW-TOP_LOG2){1'b1}}, addr[TOP_LOG2-1:0]};
      end else if (in_main) begin
        route.tgt = TGT_MAIN;
      end else if (in_top && vis) begin
        route.tgt = TGT_TOP;
      end
    end
  end
endmodule

// File: rtl/fetch_map_top.sv
module fetch_map_top
  import fetch_map_pkg::*;
#(
  parameter int MAIN_KB = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fetch_valid,
  input  logic [15:0] fetch_addr,
  input  logic        ext_access_n,
  input  logic        top_vis,
  input  logic [1:0]  shadow_sel,
  output logic        out_valid,
  output logic [1:0]  out_target,
  output logic [15:0] out_addr
);
  localparam int AW       = 16;
  localparam int TOP_KB   = 4;
  localparam int MIN_LOG2 = 10;

  logic         hit;
  fetch_route_t route;
  fetch_route_t route_q;
  logic         valid_q;

  fetch_shadow_dec #(.AW(AW), .SEL_W(2), .MIN_LOG2(MIN_LOG2)) u_dec (
    .addr(fetch_addr), .sel(shadow_sel), .hit(hit)
  );

  fetch_route_comb #(.AW(AW), .MAIN_KB(MAIN_KB), .TOP_KB(TOP_KB)) u_route (
    .addr(fetch_addr), .ext_n(ext_access_n), .vis(top_vis),
    .shadow_hit(hit), .route(route)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      route_q <= '{tgt: TGT_EXT, addr: '0};
    end else begin
      valid_q <= fetch_valid;
      if (fetch_valid) route_q <= route;
    end
  end

  assign out_valid  = valid_q;
  assign out_target = route_q.tgt;
  assign out_addr   = route_q.addr;

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> out_valid);
  // R2
  ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !ext_access_n) |=>
      (out_target == 2'd2 && out_addr == $past(fetch_addr)));
  // R8
  shadow_top_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ext_access_n && shadow_sel == 2'd3 && fetch_addr[15:12] == 4'h0) |=>
      (out_target == 2'd1 && out_addr[15:12] == 4'hF));
  // R6
  gap_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ext_access_n && fetch_addr >= 16'h8000 && fetch_addr < 16'hF000) |=>
      (out_target == 2'd2));
  // R3
  main_never_high_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_target == 2'd0) |-> (out_addr < 16'(MAIN_KB*1024)));
endmodule

// File: tb/tb_fetch_map_top.sv
module tb_fetch_map_top;
  localparam int MAIN_KB = 32;
  logic clk = 0, rst = 1;
  logic fetch_valid = 0;
  logic [15:0] fetch_addr = 0;
  logic ext_access_n = 0, top_vis = 0;
  logic [1:0] shadow_sel = 0;
  logic out_valid;
  logic [1:0] out_target;
  logic [15:0] out_addr;
  int total = 0, bad = 0;
  int exp_t, exp_a;
  bit exp_v;
  int cyc = 0;

  always #4 clk = ~clk;

  fetch_map_top #(.MAIN_KB(MAIN_KB)) dut (.*);

  function automatic void model(input int a, input bit e, input bit v,
                                input int s, output int t, output int pa);
    int lim;
    lim = (s == 0) ? 0 : (512 << s);
    t = 2; pa = a;
    if (e) begin
      if (a < lim) begin t = 1; pa = 'hF000 + (a % 4096); end
      else if (a < MAIN_KB*1024) t = 0;
      else if (a >= 'hF000 && v) t = 1;
    end
  endfunction

  function automatic string tag(input int a, input bit e, input bit v, input int s);
    if (!e) return "R2";
    if (s != 0 && a < (512 << s)) return "R7/R8/R9";
    if (a < MAIN_KB*1024) return "R3";
    if (a >= 'hF000) return v ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic check(input string r, input bit ev, input int et, input int ea);
    total++;
    if (out_valid !== ev || (ev && (out_target !== et[1:0] || out_addr !== ea[15:0]))) begin
      bad++;
      $display("FAIL %s: got v=%0d t=%0d a=%h exp v=%0d t=%0d a=%h",
               r, out_valid, out_target, out_addr, ev, et, ea[15:0]);
    end
  endtask

  task automatic step(input bit fv, input int a, input bit e, input bit v, input int s);
    string r;
    fetch_valid = fv; fetch_addr = a[15:0]; ext_access_n = e; top_vis = v;
    shadow_sel = s[1:0];
    model(a, e, v, s, exp_t, exp_a);
    r = fv ? tag(a, e, v, s) : "R1";
    @(posedge clk); #2;
    check(r, fv, exp_t, exp_a);
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int edges[12] = '{0, 'h3FF, 'h400, 'h7FF, 'h800, 'hFFF, 'h1000,
                      'h7FFF, 'h8000, 'hEFFF, 'hF000, 'hFFFF};
    int seed;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 0, 0, 0);
    rst = 0;
    step(0, 'h1234, 1, 1, 0);
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++)
        for (int v = 0; v < 2; v++)
          foreach (edges[i]) step(1, edges[i], e[0], v[0], s);
    // R9: shadow size toggled fetch by fetch at the same address
    for (int s = 0; s < 4; s++) step(1, 'h0600, 1, 0, s);
    for (int s = 3; s >= 0; s--) step(1, 'h0C10, 1, 1, s);
    step(0, 'h0000, 1, 1, 3);
    seed = 7;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom(seed + n);
      step(r[0] | r[1], (r[3] ? (r >> 8) & 'h1FFF : r >> 16) & 'hFFFF,
           r[4] | r[5], r[6], (r >> 28) & 3);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule